// File: doc/BRIEF.md
# Wake-up Clock Source Controller

This block decides which clock drives the system around low-power sleep. While the chip sleeps, a wake event from the periodic timer or from either of two port pins can start a fast internal ring oscillator. The CPU then runs on that provisional clock right away and always receives an interrupt. Software decides what happens next. It can send the chip back to sleep, which stops the ring oscillator. It can also request the real clock. In that case the block enables the main oscillator and PLL, waits for a synchronized lock indication, and moves the clock select back to the PLL output. If software asked for it, the block also raises a second, maskable interrupt.

Software talks to the block through a byte-wide control register and a write-1-to-clear event register. The clock multiplexer, the oscillators and the PLL sit outside the block. They appear here only as enable, lock and select signals. A power-down request is passed to the power sequencer through a grant output. The sequencer reports completion with a strobe. A request made while the PLL is starting up is held back and recorded as an error flag.

Top module: `wake_clk_ctrl`

## Requirements
- R1: After reset the control register and event register read 0, `clk_sel` is 0 (real clock), `pll_en` is 1, `ring_on` is 0, `irq_req` is 0, `irq_lvl` is 0 and `clko_en` is 1.
- R2: In sleep, with control bit 0 (ring enable) set, `pll_avail` high and some `wake_evt[i]` high with `wake_mask[i]` low, the next clock edge sets `ring_on`=1 and `clk_sel`=1 (ring clock) and sets event bit 0 (wake).
- R3: In sleep, a wake event does not start the ring oscillator or set any event bit if ring enable is 0, if the event's mask bit is 1, or if `pll_avail` is 0.
- R4: On the ring clock, a real-clock mode field (control bits 2:1) of 01 or 10 makes the next state start the PLL (`pll_en`=1, ring still on). A value of 00 or 11 leaves `pll_en` at 0.
- R5: `pll_lock` passes through a two-flop synchronizer. While the PLL is starting, `clk_sel` falls to 0 on the third rising edge after `pll_lock` rises, and `ring_on` falls with it.
- R6: Every switch to the real clock sets event bit 1. That bit requests an interrupt only while the mode field reads 10.
- R7: Control bits 7:6 select the interrupt level: 00 gives no interrupt, 01 gives level 1, 10 gives level 6, 11 gives level 7. `irq_req` is high while event bit 0 is set, or while event bit 1 is set with mode 10, and the selector is not 00. `irq_lvl` is 0 whenever `irq_req` is 0.
- R8: Writing the event register (`reg_sel`=1) clears every event bit written as 1 and leaves the others unchanged.
- R9: A control write that clears ring enable takes effect only while `clk_sel` is 0. On the ring clock, ring enable stays 1 and the other fields are still written.
- R10: A `pd_done` strobe on the real clock, or on the ring clock before the PLL starts, enters sleep: `ring_on`=0, `pll_en`=0, `clk_sel`=1.
- R11: `pd_go` follows `pd_req` on the real clock and on the ring clock. While the PLL is starting it stays 0, and `pd_req` sets event bit 2 (error). The hold ends on lock, or when `pll_avail` falls, which returns the block to the ring clock.
- R12: `clko_en` is 0 while control bit 3 is set and `clk_sel` is 1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = event register (write-1-to-clear) |
| reg_wdata | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control register contents (bits 5:4 read 0) |
| evt_rdata | output | 8 | Event bits: 0 wake, 1 real-clock switch, 2 power-down-while-PLL-starting |
| wake_evt | input | N_WAKE | Wake events: timer, pin A, pin B |
| wake_mask | input | N_WAKE | 1 blocks the matching wake event |
| pll_avail | input | 1 | PLL is in use in this system |
| pll_en | output | 1 | Enable for the main oscillator and PLL |
| pll_lock | input | 1 | Asynchronous PLL lock indication |
| ring_on | output | 1 | Ring oscillator enable |
| pd_req | input | 1 | Software power-down request |
| pd_go | output | 1 | Power-down request forwarded to the sequencer |
| pd_done | input | 1 | Power-down sequence complete strobe |
| clk_sel | output | 1 | System clock select: 0 real clock, 1 ring clock |
| irq_req | output | 1 | Interrupt request |
| irq_lvl | output | 3 | Interrupt priority level (0, 1, 6 or 7) |
| clko_en | output | 1 | Clock output pin enable |

## Verification
The bench tries each way a wake from sleep can be blocked: ring enable clear, a masked source, and no PLL. A design that checked only one of these conditions would start the ring clock when it should stay asleep. It counts edges after lock rises and samples the clock select on each one. A missing or extra synchronizer stage would show up as a switch one cycle early or late. It tries to clear ring enable while on the ring clock and sends a power-down request while the PLL is starting. A design that let either through would lose its clock or start power-down in the middle of PLL start-up. It also drops PLL availability during start-up to confirm that the held request is released, and it checks that the switch event requests an interrupt only under mode 10.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

    localparam int EVT_W       = 3;
    localparam int EVT_WAKE    = 0;
    localparam int EVT_SWITCH  = 1;
    localparam int EVT_PDERR   = 2;

    typedef enum logic [1:0] {
        ST_REAL  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_RING  = 2'd2,
        ST_PLLUP = 2'd3
    } wcc_state_e;

    // bit 0 ring enable, bits 2:1 real-clock mode, bit 3 clock-out off,
    // bits 5:4 unused, bits 7:6 interrupt level select
    typedef struct packed {
        logic [1:0] lvl_sel;
        logic [1:0] rsvd;
        logic       clko_off;
        logic [1:0] rc_mode;
        logic       ring_en;
    } wcc_ctrl_t;

    typedef struct packed {
        wcc_state_e state;
    } wcc_seq_t;

    function automatic logic [2:0] lvl_map(input logic [1:0] sel);
        case (sel)
            2'b01:   return 3'd1;
            2'b10:   return 3'd6;
            2'b11:   return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic rc_requested(input logic [1:0] mode);
        return (mode == 2'b01) || (mode == 2'b10);
    endfunction

endpackage

// File: rtl/wcc_lock_sync.sv
module wcc_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = async_in;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q[STAGES-1];
endmodule

// File: rtl/wcc_seq.sv
module wcc_seq
    import wcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ring_en,
    input  logic [1:0] rc_mode,
    input  logic       wake_hit,
    input  logic       pll_avail,
    input  logic       lock_s,
    input  logic       pd_req,
    input  logic       pd_done,
    output logic       pll_en,
    output logic       ring_on,
    output logic       clk_sel,
    output logic       pd_go,
    output logic       wake_fire,
    output logic       switch_fire,
    output logic       pd_hold
);
    wcc_seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        wake_fire   = 1'b0;
        switch_fire = 1'b0;
        pd_hold     = 1'b0;
        case (seq_q.state)
            ST_REAL: begin
                if (pd_done) seq_d.state = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (ring_en && wake_hit && pll_avail) begin
                    seq_d.state = ST_RING;
                    wake_fire   = 1'b1;
                end
            end
            ST_RING: begin
                if (pd_done)
                    seq_d.state = ST_SLEEP;
                else if (rc_requested(rc_mode) && pll_avail)
                    seq_d.state = ST_PLLUP;
            end
            ST_PLLUP: begin
                pd_hold = pd_req;
                if (lock_s) begin
                    seq_d.state = ST_REAL;
                    switch_fire = 1'b1;
                end else if (!pll_avail) begin
                    seq_d.state = ST_RING;
                end
            end
            default: seq_d.state = ST_REAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_REAL};
        else        seq_q <= seq_d;
    end

    assign pll_en  = (seq_q.state == ST_REAL) || (seq_q.state == ST_PLLUP);
    assign ring_on = (seq_q.state == ST_RING) || (seq_q.state == ST_PLLUP);
    assign clk_sel = (seq_q.state != ST_REAL);
    assign pd_go   = pd_req && ((seq_q.state == ST_REAL) || (seq_q.state == ST_RING));
endmodule

// File: rtl/wcc_evt_irq.sv
module wcc_evt_irq
    import wcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_fire,
    input  logic             switch_fire,
    input  logic             pd_hold,
    input  logic             clr_wr,
    input  logic [EVT_W-1:0] clr_bits,
    input  logic [1:0]       rc_mode,
    input  logic [1:0]       lvl_sel,
    output logic [EVT_W-1:0] evt_bits,
    output logic             irq_req,
    output logic [2:0]       irq_lvl
);
    logic [EVT_W-1:0] evt_d, evt_q, set_v;
    logic             pending;

    always_comb begin
        set_v              = '0;
        set_v[EVT_WAKE]    = wake_fire;
        set_v[EVT_SWITCH]  = switch_fire;
        set_v[EVT_PDERR]   = pd_hold;
        evt_d = (evt_q & ~(clr_wr ? clr_bits : '0)) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign pending  = evt_q[EVT_WAKE] || (evt_q[EVT_SWITCH] && (rc_mode == 2'b10));
    assign irq_req  = pending && (lvl_sel != 2'b00);
    assign irq_lvl  = irq_req ? lvl_map(lvl_sel) : 3'd0;
    assign evt_bits = evt_q;
endmodule

// File: rtl/wake_clk_ctrl.sv
module wake_clk_ctrl
    import wcc_pkg::*;
#(
    parameter int N_WAKE      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        ctrl_rdata,
    output logic [7:0]        evt_rdata,
    input  logic [N_WAKE-1:0] wake_evt,
    input  logic [N_WAKE-1:0] wake_mask,
    input  logic              pll_avail,
    output logic              pll_en,
    input  logic              pll_lock,
    output logic              ring_on,
    input  logic              pd_req,
    output logic              pd_go,
    input  logic              pd_done,
    output logic              clk_sel,
    output logic              irq_req,
    output logic [2:0]        irq_lvl,
    output logic              clko_en
);
    localparam int EVT_PAD = 8 - EVT_W;

    wcc_ctrl_t        ctrl_d, ctrl_q;
    logic             lock_s, wake_hit;
    logic             wake_fire, switch_fire, pd_hold;
    logic [EVT_W-1:0] evt_bits;

    // control register; a clear of ring enable is refused on the ring clock
    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && !reg_sel) begin
            ctrl_d      = wcc_ctrl_t'(reg_wdata);
            ctrl_d.rsvd = 2'b00;
            if (clk_sel && ctrl_q.ring_en) ctrl_d.ring_en = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign wake_hit = |(wake_evt & ~wake_mask);

    wcc_lock_sync #(.STAGES(SYNC_STAGES)) i_lock_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pll_lock),
        .sync_out (lock_s)
    );

    wcc_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_en     (ctrl_q.ring_en),
        .rc_mode     (ctrl_q.rc_mode),
        .wake_hit    (wake_hit),
        .pll_avail   (pll_avail),
        .lock_s      (lock_s),
        .pd_req      (pd_req),
        .pd_done     (pd_done),
        .pll_en      (pll_en),
        .ring_on     (ring_on),
        .clk_sel     (clk_sel),
        .pd_go       (pd_go),
        .wake_fire   (wake_fire),
        .switch_fire (switch_fire),
        .pd_hold     (pd_hold)
    );

    wcc_evt_irq i_evt_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_fire   (wake_fire),
        .switch_fire (switch_fire),
        .pd_hold     (pd_hold),
        .clr_wr      (reg_wr && reg_sel),
        .clr_bits    (reg_wdata[EVT_W-1:0]),
        .rc_mode     (ctrl_q.rc_mode),
        .lvl_sel     (ctrl_q.lvl_sel),
        .evt_bits    (evt_bits),
        .irq_req     (irq_req),
        .irq_lvl     (irq_lvl)
    );

    assign ctrl_rdata = ctrl_q;
    assign evt_rdata  = {{EVT_PAD{1'b0}}, evt_bits};
    assign clko_en    = !(ctrl_q.clko_off && clk_sel);
endmodule

// File: rtl/wcc_checker.sv
module wcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_ring_en,
    input logic       ctrl_clko_off,
    input logic       evt_wake,
    input logic       pll_avail,
    input logic       pll_en,
    input logic       ring_on,
    input logic       clk_sel,
    input logic       pd_go,
    input logic       irq_req,
    input logic [2:0] irq_lvl,
    input logic       clko_en
);
    p_wake_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_on) |-> evt_wake);

    p_ring_needs_pll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_on) |-> ($past(pll_avail) && $past(ctrl_ring_en)));

    p_switch_stops_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_sel) |-> (!ring_on && pll_en));

    p_lvl_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl == 3'd1 || irq_lvl == 3'd6 || irq_lvl == 3'd7));

    p_lvl_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_lvl == 3'd0));

    p_ring_en_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_sel) && $past(ctrl_ring_en)) |-> ctrl_ring_en);

    p_pd_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en && clk_sel) |-> !pd_go);

    p_clko_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && ctrl_clko_off) |-> !clko_en);
endmodule

bind wake_clk_ctrl wcc_checker i_wcc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_ring_en  (ctrl_rdata[0]),
    .ctrl_clko_off (ctrl_rdata[3]),
    .evt_wake      (evt_rdata[0]),
    .pll_avail     (pll_avail),
    .pll_en        (pll_en),
    .ring_on       (ring_on),
    .clk_sel       (clk_sel),
    .pd_go         (pd_go),
    .irq_req       (irq_req),
    .irq_lvl       (irq_lvl),
    .clko_en       (clko_en)
);

// File: tb/test_wake_clk_ctrl.sv
`timescale 1ns/1ps
module test_wake_clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctrl_rdata, evt_rdata;
    logic [2:0] wake_evt = 3'b000, wake_mask = 3'b000;
    logic       pll_avail = 1'b1, pll_lock = 1'b0, pd_req = 1'b0, pd_done = 1'b0;
    logic       pll_en, ring_on, pd_go, clk_sel, irq_req, clko_en;
    logic [2:0] irq_lvl;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    wake_clk_ctrl i_wake_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .evt_rdata(evt_rdata),
        .wake_evt(wake_evt), .wake_mask(wake_mask), .pll_avail(pll_avail),
        .pll_en(pll_en), .pll_lock(pll_lock), .ring_on(ring_on),
        .pd_req(pd_req), .pd_go(pd_go), .pd_done(pd_done), .clk_sel(clk_sel),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .clko_en(clko_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic t_reset();
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 pll_en", pll_en, 1);
        chk("R1 ring_on", ring_on, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_lvl", irq_lvl, 0);
        chk("R1 ctrl", ctrl_rdata, 8'h00);
        chk("R1 evt", evt_rdata, 8'h00);
        chk("R1 clko_en", clko_en, 1);
    endtask

    task automatic t_blocked_wake();
        wr_reg(1'b0, 8'h80);
        pd_req = 1'b1; #1;
        chk("R11 pd_go on real clock", pd_go, 1);
        pd_done = 1'b1; step(); pd_done = 1'b0; pd_req = 1'b0;
        chk("R10 sleep clk_sel", clk_sel, 1);
        chk("R10 sleep pll_en", pll_en, 0);
        chk("R10 sleep ring_on", ring_on, 0);
        wake_evt = 3'b001; step(); wake_evt = 3'b000; step();
        chk("R3 ring enable clear", ring_on, 0);
        chk("R3 no event bit", evt_rdata, 8'h00);
        wr_reg(1'b0, 8'h81);
        wake_mask = 3'b010; wake_evt = 3'b010; step(); wake_evt = 3'b000; step();
        chk("R3 masked source", ring_on, 0);
        pll_avail = 1'b0; wake_evt = 3'b001; step(); wake_evt = 3'b000; pll_avail = 1'b1; step();
        chk("R3 pll unavailable", ring_on, 0);
        chk("R3 no event bit after blocked", evt_rdata, 8'h00);
    endtask

    task automatic t_wake();
        wake_evt = 3'b100; step(); wake_evt = 3'b000;
        chk("R2 ring_on", ring_on, 1);
        chk("R2 clk_sel", clk_sel, 1);
        chk("R2 pll_en stays off", pll_en, 0);
        chk("R2 wake event bit", evt_rdata, 8'h01);
        chk("R7 irq_req", irq_req, 1);
        chk("R7 level 6", irq_lvl, 6);
    endtask

    task automatic t_ring_ctrl();
        wr_reg(1'b0, 8'h80);
        chk("R9 clear refused on ring clock", ctrl_rdata, 8'h81);
        wr_reg(1'b0, 8'h89);
        chk("R12 clko disabled on ring", clko_en, 0);
        wr_reg(1'b0, 8'h81);
        chk("R12 clko restored", clko_en, 1);
        wr_reg(1'b0, 8'h87);
        step(); step();
        chk("R4 mode 11 keeps pll off", pll_en, 0);
        chk("R4 mode 11 ring on", ring_on, 1);
    endtask

    task automatic t_levels();
        wr_reg(1'b0, 8'h41); chk("R7 level 1", irq_lvl, 1);
        wr_reg(1'b0, 8'hC1); chk("R7 level 7", irq_lvl, 7);
        wr_reg(1'b0, 8'h01);
        chk("R7 selector 00 no irq", irq_req, 0);
        chk("R7 selector 00 level", irq_lvl, 0);
        wr_reg(1'b0, 8'h81); chk("R7 level 6 again", irq_lvl, 6);
        wr_reg(1'b1, 8'h01);
        chk("R8 wake bit cleared", evt_rdata, 8'h00);
        chk("R8 irq dropped", irq_req, 0);
    endtask

    task automatic t_switch();
        wr_reg(1'b0, 8'h85);
        step();
        chk("R4 mode 10 pll_en", pll_en, 1);
        chk("R4 mode 10 still ring", clk_sel, 1);
        pd_req = 1'b1; #1;
        chk("R11 pd_go held", pd_go, 0);
        step();
        chk("R11 error bit", evt_rdata, 8'h04);
        pll_lock = 1'b1;
        step(); chk("R5 edge 1 still ring", clk_sel, 1);
        step(); chk("R5 edge 2 still ring", clk_sel, 1);
        step();
        chk("R5 edge 3 real clock", clk_sel, 0);
        chk("R5 ring off", ring_on, 0);
        chk("R6 switch bit", evt_rdata, 8'h06);
        chk("R6 irq under mode 10", irq_req, 1);
        chk("R6 level", irq_lvl, 6);
        chk("R11 pd_go released on lock", pd_go, 1);
        pd_req = 1'b0;
        wr_reg(1'b0, 8'h83);
        chk("R6 switch bit masked in mode 01", irq_req, 0);
        wr_reg(1'b1, 8'h06);
        chk("R8 clear two bits", evt_rdata, 8'h00);
        wr_reg(1'b0, 8'h82);
        chk("R9 clear allowed on real clock", ctrl_rdata, 8'h82);
        wr_reg(1'b0, 8'h83);
    endtask

    task automatic t_pll_drop();
        pll_lock = 1'b0; pd_req = 1'b1; pd_done = 1'b1;
        step(); pd_done = 1'b0; pd_req = 1'b0;
        chk("R10 sleep from real", ring_on, 0);
        wake_evt = 3'b001; step(); wake_evt = 3'b000;
        chk("R2 timer wake", ring_on, 1);
        step();
        chk("R4 mode 01 pll_en", pll_en, 1);
        pd_req = 1'b1; #1;
        chk("R11 held during startup", pd_go, 0);
        pll_avail = 1'b0; step(); #1;
        chk("R11 back to ring pll_en", pll_en, 0);
        chk("R11 released on pll loss", pd_go, 1);
        pd_done = 1'b1; step(); pd_done = 1'b0; pd_req = 1'b0;
        chk("R10 ring off after power-down", ring_on, 0);
        chk("R10 pll off in sleep", pll_en, 0);
        chk("R10 select in sleep", clk_sel, 1);
        pll_avail = 1'b1;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_blocked_wake();
        t_wake();
        t_ring_ctrl();
        t_levels();
        t_switch();
        t_pll_drop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule